// File: doc/BRIEF.md
# Single-Bus MOVE Processor

A compact 16-bit processor whose every internal register transfer crosses one shared bus. It fetches one instruction word at a time from an external word-addressed memory. It decodes a source addressing mode and a destination addressing mode, copies one operand from the source to the destination, and stops for good on a halt opcode. Each register has a load enable and a bus-drive enable. The sequencer raises at most one drive enable in any cycle, so the OR-combined bus behaves like a tri-state line that never has two drivers.

The memory port is synchronous. An address comes from the memory address register, and read data is returned one clock later. A write is a single cycle with the write enable high, carrying the memory data register as its data. The four general registers can be read at any time through a combinational debug port, so a program's results can be inspected after it halts.

Top module: `bus_move_cpu`

## Requirements
- R1: While the synchronous reset is high: `halted` is 0, `mem_we` is 0, `mem_addr` is 0 and all four general registers read 0. After release, the first instruction is fetched from address 0 and the following ones from successive addresses.
- R2: An instruction word holds opcode [15:13], source mode [12:11], source register [10:9], destination mode [8], destination register [7:6] and a 6-bit constant [5:0]. Opcode 000 is a move: the destination receives the source operand.
- R3: Source mode 00 (register direct) gives the contents of the selected register Rn.
- R4: Source mode 01 (register indirect) gives the memory word at the address held in Rn.
- R5: Source mode 10 (immediate) gives the constant sign-extended to 16 bits, so 6'h3F gives 16'hFFFF, 6'h20 gives 16'hFFE0 and 6'h1F gives 16'h001F. The register field is ignored in this mode.
- R6: Source mode 11 (absolute) gives the memory word at the zero-extended constant, so a constant of 40 reads address 40.
- R7: Destination mode 0 writes register Rn. Destination mode 1 writes memory at the zero-extended constant and leaves all general registers unchanged.
- R8: Opcode 111 sets `halted`. From then until reset, no memory write occurs and the general registers keep their values.
- R9: Any opcode other than 000 and 111 is skipped. It changes no register and writes no memory, and execution continues with the next word.
- R10: At most one source drives the internal bus in any cycle, and every bus load has exactly one driver. Any program of moves leaves registers and memory equal to sequential execution of its instructions.
- R11: Memory read data is taken one cycle after the address is presented. Each move to a memory destination makes exactly one single-cycle write.
- R12: `dbg_data` shows the general register selected by `dbg_sel` (0 to 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per write |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has been executed |
| dbg_sel | input | 2 | General register select for the debug port |
| dbg_data | output | 16 | Contents of the selected general register |

## Verification
A wrong sequencer state or a wrongly decoded field is visible at the ports within the same instruction. It shows up as an unexpected `mem_addr`, a write with the wrong data or at the wrong address, or a register value on the debug port that differs from sequential execution once `halted` rises. A bus conflict or a missed load does not reach the ports until an operand is consumed, so randomly generated programs are compared word by word against a bench-side instruction model over the whole memory image and all four registers. After halting, the bench keeps watching for some time, so that a sequencer that leaves the stop state shows up as a stray write or a changed register.

// File: rtl/bus_move_cpu.sv
module bus_move_cpu (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  input  logic [15:0] mem_rdata,
  output logic        halted,
  input  logic [1:0]  dbg_sel,
  output logic [15:0] dbg_data
);

  typedef enum logic [3:0] {
    F_ADDR, F_INC, F_LATCH, F_IR, DECODE,
    S_ADDR, S_WAIT, S_LATCH, XFER, D_ADDR, D_WRITE, STOP
  } state_t;

  state_t st, nxt;
  logic [15:0] pc, ir, mar, mdr, bus;
  logic [3:0][15:0] gp;

  logic [2:0] op;
  logic [1:0] smode, sreg, dreg;
  logic       dmode;
  logic [5:0] k;
  assign {op, smode, sreg, dmode, dreg, k} = ir;

  logic oe_pc, oe_mdr, oe_imm, oe_abs;
  logic [3:0] oe_r, ie_r;
  logic ie_mar, ie_ir, ie_mdr, ld_mdr_mem, inc_pc;

  always_comb begin
    {oe_pc, oe_mdr, oe_imm, oe_abs, ie_mar, ie_ir, ie_mdr, ld_mdr_mem, inc_pc, mem_we} = '0;
    oe_r = '0;
    ie_r = '0;
    unique case (st)
      F_ADDR:  begin oe_pc = 1'b1; ie_mar = 1'b1; end
      F_INC:   inc_pc = 1'b1;
      F_LATCH: ld_mdr_mem = 1'b1;
      F_IR:    begin oe_mdr = 1'b1; ie_ir = 1'b1; end
      S_ADDR: begin
        if (smode == 2'b01) oe_r[sreg] = 1'b1;
        else oe_abs = 1'b1;
        ie_mar = 1'b1;
      end
      S_LATCH: ld_mdr_mem = 1'b1;
      XFER: begin
        case (smode)
          2'b00:   oe_r[sreg] = 1'b1;
          2'b10:   oe_imm = 1'b1;
          default: oe_mdr = 1'b1;
        endcase
        if (dmode) ie_mdr = 1'b1;
        else ie_r[dreg] = 1'b1;
      end
      D_ADDR:  begin oe_abs = 1'b1; ie_mar = 1'b1; end
      D_WRITE: mem_we = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    bus = '0;
    if (oe_pc)  bus = bus | pc;
    if (oe_mdr) bus = bus | mdr;
    if (oe_imm) bus = bus | {{10{k[5]}}, k};
    if (oe_abs) bus = bus | {10'b0, k};
    for (int i = 0; i < 4; i++)
      if (oe_r[i]) bus = bus | gp[i];
  end

  always_comb begin
    case (st)
      F_ADDR:  nxt = F_INC;
      F_INC:   nxt = F_LATCH;
      F_LATCH: nxt = F_IR;
      F_IR:    nxt = DECODE;
      DECODE:  nxt = (op == 3'b111) ? STOP :
                     (op != 3'b000) ? F_ADDR :
                     smode[0] ? S_ADDR : XFER;
      S_ADDR:  nxt = S_WAIT;
      S_WAIT:  nxt = S_LATCH;
      S_LATCH: nxt = XFER;
      XFER:    nxt = dmode ? D_ADDR : F_ADDR;
      D_ADDR:  nxt = D_WRITE;
      D_WRITE: nxt = F_ADDR;
      default: nxt = STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= F_ADDR;
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      gp  <= '0;
    end else begin
      st <= nxt;
      if (inc_pc) pc <= pc + 16'd1;
      if (ie_mar) mar <= bus;
      if (ie_ir) ir <= bus;
      if (ld_mdr_mem) mdr <= mem_rdata;
      else if (ie_mdr) mdr <= bus;
      for (int i = 0; i < 4; i++)
        if (ie_r[i]) gp[i] <= bus;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign halted    = (st == STOP);
  assign dbg_data  = gp[dbg_sel];

  logic [7:0] oe_all;
  logic       ie_any;
  assign oe_all = {oe_pc, oe_mdr, oe_imm, oe_abs, oe_r};
  assign ie_any = ie_mar | ie_ir | ie_mdr | (|ie_r);

  p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe_all));
  p_load_driven_r10: assert property (@(posedge clk) disable iff (rst)
    ie_any |-> ($countones(oe_all) == 1));
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_halt_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(gp) && $stable(mar)));
  p_single_write_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

// File: tb/test_bus_move_cpu.sv
`timescale 1ns/1ps
module test_bus_move_cpu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic        mem_we, halted;
  logic [1:0]  dbg_sel = 2'd0;

  bus_move_cpu i_bus_move_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  logic [15:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  logic        wr_clr = 1'b0;
  int          wr_count = 0;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (wr_clr) wr_count <= 0;
    else if (mem_we) wr_count <= wr_count + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [15:0] img [256];
  logic [15:0] ref_mem [256];
  logic [15:0] ref_r [4];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mv(int sm, int sr, int dm, int dr, int k);
    return {3'b000, 2'(sm), 2'(sr), 1'(dm), 2'(dr), 6'(k)};
  endfunction

  task automatic run_ref();
    logic [15:0] pc, ir, v;
    pc = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
    for (int i = 0; i < 4; i++) ref_r[i] = 16'h0;
    for (int step = 0; step < 200; step++) begin
      ir = ref_mem[pc[7:0]];
      pc = pc + 1;
      if (ir[15:13] == 3'b111) break;
      if (ir[15:13] != 3'b000) continue;
      case (ir[12:11])
        2'b00: v = ref_r[ir[10:9]];
        2'b01: v = ref_mem[ref_r[ir[10:9]][7:0]];
        2'b10: v = {{10{ir[5]}}, ir[5:0]};
        default: v = ref_mem[ir[5:0]];
      endcase
      if (ir[8]) ref_mem[ir[5:0]] = v;
      else ref_r[ir[7:6]] = v;
    end
  endtask

  task automatic read_reg(int n, output logic [15:0] v);
    dbg_sel = 2'(n);
    #1;
    v = dbg_data;
  endtask

  task automatic load_and_run();
    logic [15:0] v;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_a = 8'(i); ld_d = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0; wr_clr = 1'b1;
    @(negedge clk);
    wr_clr = 1'b0;
    chk("R1", "halted in reset", {15'b0, halted}, 16'h0);
    chk("R1", "mem_we in reset", {15'b0, mem_we}, 16'h0);
    chk("R1", "mem_addr in reset", mem_addr, 16'h0);
    for (int r = 0; r < 4; r++) begin
      read_reg(r, v);
      chk("R1", "register after reset", v, 16'h0);
    end
    rst = 1'b0;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    chk("R8", "halted after program", {15'b0, halted}, 16'h1);
  endtask

  task automatic compare_all(string req);
    logic [15:0] v;
    int bad;
    run_ref();
    for (int r = 0; r < 4; r++) begin
      read_reg(r, v);
      chk(req, "register via debug port", v, ref_r[r]);
    end
    bad = -1;
    for (int a = 0; a < 256; a++)
      if (bad < 0 && mem[a] !== ref_mem[a]) bad = a;
    if (bad < 0) chk(req, "memory image", 16'h0, 16'h0);
    else chk(req, $sformatf("memory word %0d", bad), mem[bad], ref_mem[bad]);
  endtask

  function automatic logic [15:0] rand_instr();
    int sm, dm, k, op;
    sm = $urandom_range(0, 3);
    dm = $urandom_range(0, 1);
    k  = dm ? $urandom_range(16, 63) : $urandom_range(0, 63);
    op = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 6) : 0;
    return {3'(op), 2'(sm), 2'($urandom_range(0, 3)), 1'(dm),
            2'($urandom_range(0, 3)), 6'(k)};
  endfunction

  initial begin
    logic [15:0] v, snap [4];
    int wc;
    void'($urandom(32'd2718));

    // directed: the reference program
    for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
    img[0] = mv(2, 0, 0, 0, 21);
    img[1] = mv(3, 0, 0, 1, 20);
    img[2] = mv(1, 0, 0, 2, 0);
    img[3] = mv(0, 0, 1, 0, 23);
    img[4] = mv(2, 0, 0, 3, 6'h3F);
    img[5] = mv(1, 1, 1, 0, 24);
    img[6] = 16'hE000;
    img[20] = 16'd22; img[21] = 16'h1234; img[22] = 16'hBEEF;
    load_and_run();
    read_reg(0, v); chk("R5", "R0 = #21", v, 16'd21);
    read_reg(1, v); chk("R6", "R1 = mem[20]", v, 16'd22);
    read_reg(2, v); chk("R4", "R2 = mem[(R0)]", v, 16'h1234);
    read_reg(3, v); chk("R5", "R3 = #-1", v, 16'hFFFF);
    chk("R7", "mem[23] = R0", mem[23], 16'd21);
    chk("R11", "mem[24] = mem[(R1)]", mem[24], 16'hBEEF);
    chk("R11", "write count", 16'(wr_count), 16'd2);
    compare_all("R10");

    // R8: state holds after halt
    for (int r = 0; r < 4; r++) read_reg(r, snap[r]);
    wc = wr_count;
    repeat (25) @(negedge clk);
    chk("R8", "halted stays", {15'b0, halted}, 16'h1);
    chk("R8", "no writes after halt", 16'(wr_count), 16'(wc));
    for (int r = 0; r < 4; r++) begin
      read_reg(r, v);
      chk("R8", "register held after halt", v, snap[r]);
    end

    // directed: extension and field corners
    for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
    img[0] = mv(3, 0, 0, 0, 40);
    img[1] = mv(0, 0, 1, 0, 45);
    img[2] = mv(2, 0, 0, 1, 6'h1F);
    img[3] = mv(2, 0, 0, 2, 6'h20);
    img[4] = mv(0, 1, 0, 3, 0);
    img[5] = mv(2, 3, 0, 0, 7);
    img[6] = 16'hE000;
    img[40] = 16'h0A0A;
    v = img[8'hED];
    load_and_run();
    chk("R6", "absolute write at zero-extended 45", mem[45], 16'h0A0A);
    chk("R7", "sign-extended address untouched", mem[8'hED], v);
    read_reg(1, v); chk("R5", "#31 positive", v, 16'h001F);
    read_reg(2, v); chk("R5", "#-32", v, 16'hFFE0);
    read_reg(3, v); chk("R3", "R3 = R1 direct", v, 16'h001F);
    read_reg(0, v); chk("R5", "register field ignored on immediate", v, 16'd7);
    chk("R11", "one write", 16'(wr_count), 16'd1);
    compare_all("R2");

    // R9: unused opcodes skipped
    for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
    img[0] = {3'b010, 2'b10, 2'b00, 1'b0, 2'b00, 6'd5};
    img[1] = {3'b001, 2'b10, 2'b00, 1'b1, 2'b00, 6'd50};
    img[2] = {3'b110, 2'b10, 2'b00, 1'b0, 2'b01, 6'd9};
    img[3] = mv(2, 0, 0, 2, 3);
    img[4] = 16'hE000;
    v = img[50];
    load_and_run();
    read_reg(0, snap[0]); chk("R9", "R0 untouched", snap[0], 16'h0);
    read_reg(1, snap[1]); chk("R9", "R1 untouched", snap[1], 16'h0);
    read_reg(2, snap[2]); chk("R9", "move after skipped words runs", snap[2], 16'd3);
    chk("R9", "no memory write", 16'(wr_count), 16'd0);
    chk("R9", "mem[50] untouched", mem[50], v);

    // random programs
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
      for (int i = 0; i < 12; i++) img[i] = rand_instr();
      img[12] = 16'hE000;
      load_and_run();
      compare_all("R12");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule